// File: doc/BRIEF.md
# Generic Command Packet Front End for a Display Serial Link

This block sits between a host register bus and the packet layer of a display serial link. The host loads outgoing payload words into a write-payload queue through a shared data register. It then commits the packet by writing its header word into a command queue. A sequencer turns each queued header into a beat on a valid/ready transmit stream, followed by the payload words that packet needs. Response words from the link arrive on a valid/ready receive stream and wait in a read-payload queue. The host drains that queue through the same data register.

A status register shows an empty and a full flag for every queue. It also shows a read-in-progress flag and a sticky flag that records a dropped write. Software polls the status register to pace itself. A transfer is finished once the command queue and the write-payload queue are both empty.

Back-pressure rules: a transmit beat moves only on a cycle where `tx_valid` and `tx_ready` are both high. While `tx_valid` is high and `tx_ready` is low, the beat and its flags stay unchanged. The block lowers `rx_ready` whenever the read-payload queue is full. A receive beat is taken only on a cycle where `rx_valid` and `rx_ready` are both high.

Top module: `pktcmd_front`

## Requirements
- R1: After reset, the status register (byte offset 0x74) reads 0x15, `tx_valid` is low and `rx_ready` is high.
- R2: No transmit beat is offered until a header word has been written to offset 0x6C. Payload words written to offset 0x70 alone never start a packet.
- R3: Each packet leaves as one header beat followed by its payload beats. The header beat has `tx_hdr`=1 and carries the written header word unchanged. A header whose bits 3:0 equal 0x9 is a long packet and is followed by ceil(N/4) payload beats, where N is header bits 23:8. Any other header is a short packet and is sent alone. `tx_last` marks the final beat of each packet.
- R4: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data`, `tx_hdr` and `tx_last` hold their values.
- R5: Status bit 0 is set when the command queue (4 headers) is empty and bit 1 when it is full. Bit 2 is set when the write-payload queue (16 words) is empty and bit 3 when it is full. Payload words leave in the order they were written.
- R6: A header or payload write to a full queue is dropped and sets sticky status bit 7. Writing 0x74 with bit 7 set clears bit 7. Writing 0x74 with bit 7 clear leaves it unchanged.
- R7: Status bit 6 is set once a header with bits 3:0 equal to 0x4 or 0x6 has been accepted on the transmit stream. It stays set until a receive beat with `rx_last`=1 is accepted.
- R8: Receive words are stored in a 16-word read-payload queue. Status bit 4 is set when that queue is empty and bit 5 when it is full, and `rx_ready` is low while it is full.
- R9: A read of offset 0x70 returns the oldest stored receive word and removes it. When the read-payload queue is empty, such a read returns zero and changes nothing.
- R10: Once every committed packet has been fully sent, status bits 0 and 2 both read as set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of 0x70 pops on the clock edge |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| tx_valid | output | 1 | Transmit beat available |
| tx_ready | input | 1 | Link accepts transmit beat |
| tx_data | output | 32 | Header word or payload word |
| tx_hdr | output | 1 | Beat is a packet header |
| tx_last | output | 1 | Final beat of the packet |
| rx_valid | input | 1 | Receive word available |
| rx_ready | output | 1 | Read-payload queue can take a word |
| rx_data | input | 32 | Receive word, lowest byte in bits 7:0 |
| rx_last | input | 1 | Final word of a read response |

## Verification
The assertions assume that the link side obeys the valid/ready rules above and never pulses `rx_last` unless a read is pending. They also assume that `reg_wr` and `reg_rd` are never high in the same cycle. The stimulus drives one register access at a time. It asserts `rx_last` only on the final word of a response that follows a read-request header. The transmit sink toggles `tx_ready` at random, so stalls are tested without breaking the handshake rules.

// File: rtl/pktcmd_pkg.sv
package pktcmd_pkg;
  localparam int DW = 32;
  localparam int REG_AW = 8;
  localparam int WCW = 16;

  localparam logic [REG_AW-1:0] OFS_HDR  = 8'h6C;
  localparam logic [REG_AW-1:0] OFS_DATA = 8'h70;
  localparam logic [REG_AW-1:0] OFS_STAT = 8'h74;

  localparam int ST_CMD_EMPTY = 0;
  localparam int ST_CMD_FULL  = 1;
  localparam int ST_WP_EMPTY  = 2;
  localparam int ST_WP_FULL   = 3;
  localparam int ST_RP_EMPTY  = 4;
  localparam int ST_RP_FULL   = 5;
  localparam int ST_RD_BUSY   = 6;
  localparam int ST_OVF       = 7;

  typedef enum logic {SQ_HDR, SQ_PLD} seq_state_e;

  function automatic logic hdr_is_long(input logic [DW-1:0] h);
    return h[3:0] == 4'h9;
  endfunction

  function automatic logic hdr_is_read(input logic [DW-1:0] h);
    return (h[3:0] == 4'h4) || (h[3:0] == 4'h6);
  endfunction

  function automatic logic [WCW-1:0] hdr_count(input logic [DW-1:0] h);
    return h[8 +: WCW];
  endfunction
endpackage

// File: rtl/pktcmd_fifo.sv
module pktcmd_fifo #(
  parameter int W = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R6
  fifo_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (full && $stable(count)));

  // R9
  fifo_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> (empty && $stable(rptr)));
endmodule

// File: rtl/pktcmd_regs.sv
module pktcmd_regs
  import pktcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              cmd_empty,
  input  logic              cmd_full,
  input  logic              wp_empty,
  input  logic              wp_full,
  input  logic              rp_empty,
  input  logic              rp_full,
  input  logic [DW-1:0]     rp_head,
  input  logic              rd_busy,
  output logic              cmd_push,
  output logic              wp_push,
  output logic              rp_pop
);
  logic ovf, ovf_set, ovf_clr;
  logic [DW-1:0] status;

  assign cmd_push = reg_wr && (reg_addr == OFS_HDR);
  assign wp_push  = reg_wr && (reg_addr == OFS_DATA);
  assign rp_pop   = reg_rd && (reg_addr == OFS_DATA) && !rp_empty;
  assign ovf_set  = (cmd_push && cmd_full) || (wp_push && wp_full);
  assign ovf_clr  = reg_wr && (reg_addr == OFS_STAT) && reg_wdata[ST_OVF];

  always_ff @(posedge clk) begin
    if (!rst_n)       ovf <= 1'b0;
    else if (ovf_set) ovf <= 1'b1;
    else if (ovf_clr) ovf <= 1'b0;
  end

  always_comb begin
    status = '0;
    status[ST_CMD_EMPTY] = cmd_empty;
    status[ST_CMD_FULL]  = cmd_full;
    status[ST_WP_EMPTY]  = wp_empty;
    status[ST_WP_FULL]   = wp_full;
    status[ST_RP_EMPTY]  = rp_empty;
    status[ST_RP_FULL]   = rp_full;
    status[ST_RD_BUSY]   = rd_busy;
    status[ST_OVF]       = ovf;
  end

  always_comb begin
    case (reg_addr)
      OFS_STAT: reg_rdata = status;
      OFS_DATA: reg_rdata = rp_empty ? '0 : rp_head;
      default:  reg_rdata = '0;
    endcase
  end

  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(reg_wr && (reg_addr == OFS_STAT) && reg_wdata[ST_OVF])) |=> ovf);
endmodule

// File: rtl/pktcmd_seq.sv
module pktcmd_seq
  import pktcmd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_empty,
  input  logic [DW-1:0] cmd_head,
  output logic          cmd_pop,
  input  logic          wp_empty,
  input  logic [DW-1:0] wp_head,
  output logic          wp_pop,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [DW-1:0] tx_data,
  output logic          tx_hdr,
  output logic          tx_last,
  input  logic          rx_done,
  output logic          rd_busy
);
  localparam int CNTW = WCW - 1;

  seq_state_e      state;
  logic [CNTW-1:0] remain;
  logic [WCW:0]    wc_round;
  logic [CNTW-1:0] hdr_words;
  logic            hdr_has_pld;
  logic            hdr_fire, pld_fire;

  assign wc_round    = {1'b0, hdr_count(cmd_head)} + (WCW + 1)'(3);
  assign hdr_words   = wc_round[WCW:2];
  assign hdr_has_pld = hdr_is_long(cmd_head) && (hdr_words != '0);

  always_comb begin
    if (state == SQ_HDR) begin
      tx_valid = !cmd_empty;
      tx_data  = cmd_head;
      tx_hdr   = 1'b1;
      tx_last  = !hdr_has_pld;
    end else begin
      tx_valid = !wp_empty;
      tx_data  = wp_head;
      tx_hdr   = 1'b0;
      tx_last  = (remain == CNTW'(1));
    end
  end

  assign hdr_fire = (state == SQ_HDR) && tx_valid && tx_ready;
  assign pld_fire = (state == SQ_PLD) && tx_valid && tx_ready;
  assign cmd_pop  = hdr_fire;
  assign wp_pop   = pld_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= SQ_HDR;
      remain <= '0;
    end else if (hdr_fire && hdr_has_pld) begin
      state  <= SQ_PLD;
      remain <= hdr_words;
    end else if (pld_fire) begin
      remain <= remain - 1'b1;
      if (remain == CNTW'(1)) state <= SQ_HDR;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_busy <= 1'b0;
    else if (hdr_fire && hdr_is_read(cmd_head)) rd_busy <= 1'b1;
    else if (rx_done) rd_busy <= 1'b0;
  end

  // R4
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=>
      (tx_valid && $stable(tx_data) && $stable(tx_hdr) && $stable(tx_last)));

  // R3
  hdr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_hdr && !tx_last) |=> !tx_hdr);

  // R7
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !(hdr_fire && hdr_is_read(cmd_head))) |=> !rd_busy);
endmodule

// File: rtl/pktcmd_front.sv
module pktcmd_front
  import pktcmd_pkg::*;
#(
  parameter int CMD_DEPTH = 4,
  parameter int PLD_DEPTH = 16,
  parameter int RD_DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DW-1:0]     tx_data,
  output logic              tx_hdr,
  output logic              tx_last,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DW-1:0]     rx_data,
  input  logic              rx_last
);
  logic          cmd_push, cmd_pop, cmd_empty, cmd_full;
  logic          wp_push, wp_pop, wp_empty, wp_full;
  logic          rp_push, rp_pop, rp_empty, rp_full;
  logic [DW-1:0] cmd_head, wp_head, rp_head;
  logic          rd_busy, rx_done;

  assign rx_ready = !rp_full;
  assign rp_push  = rx_valid && rx_ready;
  assign rx_done  = rp_push && rx_last;

  pktcmd_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cmd_empty(cmd_empty), .cmd_full(cmd_full),
    .wp_empty(wp_empty), .wp_full(wp_full),
    .rp_empty(rp_empty), .rp_full(rp_full), .rp_head(rp_head),
    .rd_busy(rd_busy),
    .cmd_push(cmd_push), .wp_push(wp_push), .rp_pop(rp_pop)
  );

  pktcmd_fifo #(.W(DW), .DEPTH(CMD_DEPTH)) u_cmd_q (
    .clk(clk), .rst_n(rst_n), .push(cmd_push), .din(reg_wdata),
    .pop(cmd_pop), .dout(cmd_head), .empty(cmd_empty), .full(cmd_full)
  );

  pktcmd_fifo #(.W(DW), .DEPTH(PLD_DEPTH)) u_wp_q (
    .clk(clk), .rst_n(rst_n), .push(wp_push), .din(reg_wdata),
    .pop(wp_pop), .dout(wp_head), .empty(wp_empty), .full(wp_full)
  );

  pktcmd_fifo #(.W(DW), .DEPTH(RD_DEPTH)) u_rp_q (
    .clk(clk), .rst_n(rst_n), .push(rp_push), .din(rx_data),
    .pop(rp_pop), .dout(rp_head), .empty(rp_empty), .full(rp_full)
  );

  pktcmd_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_empty(cmd_empty), .cmd_head(cmd_head), .cmd_pop(cmd_pop),
    .wp_empty(wp_empty), .wp_head(wp_head), .wp_pop(wp_pop),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_hdr(tx_hdr), .tx_last(tx_last),
    .rx_done(rx_done), .rd_busy(rd_busy)
  );

  // R8
  rx_full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !rp_pop) |=> !rx_ready);
endmodule

// File: tb/test_pktcmd_front.sv
module test_pktcmd_front;
  localparam logic [7:0] A_HDR = 8'h6C, A_DATA = 8'h70, A_STAT = 8'h74;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic tx_valid, tx_hdr, tx_last;
  logic tx_ready = 1'b0;
  logic [31:0] tx_data;
  logic rx_valid = 1'b0, rx_last = 1'b0, rx_ready;
  logic [31:0] rx_data = '0;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0, sink_en = 0;
  int ready_pct = 100;
  logic [31:0] got_data[$];
  logic [1:0]  got_flag[$];
  bit prev_stall = 0;
  logic [31:0] prev_data;
  logic [1:0] prev_flag;

  always #10 clk = ~clk;

  pktcmd_front i_pktcmd_front (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_hdr(tx_hdr), .tx_last(tx_last),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_last(rx_last)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] stat_exp(bit ce, bit cf, bit we, bit wf, bit re, bit rf, bit busy, bit ovf);
    return {24'h0, ovf, busy, rf, re, wf, we, cf, ce};
  endfunction

  function automatic int words_for(logic [31:0] h);
    if (h[3:0] == 4'h9) return (int'(h[23:8]) + 3) / 4;
    return 0;
  endfunction

  // transmit sink and stall monitor
  always @(negedge clk) begin
    if (prev_stall) begin
      checks++;
      if (!(tx_valid && tx_data == prev_data && {tx_hdr, tx_last} == prev_flag)) begin
        fails++;
        $display("FAIL R4 stalled beat changed actual=%h expected=%h", tx_data, prev_data);
      end
    end
    tx_ready = rst_n && sink_en && (int'($urandom_range(0, 99)) < ready_pct);
    #1;
    if (rst_n && tx_valid && tx_ready) begin
      got_data.push_back(tx_data);
      got_flag.push_back({tx_hdr, tx_last});
    end
    prev_stall = rst_n && tx_valid && !tx_ready;
    prev_data  = tx_data;
    prev_flag  = {tx_hdr, tx_last};
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #5 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic send_rx(input logic [31:0] d, input bit last);
    int t = 0;
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_last = last;
    #1;
    while (!rx_ready && t < 100) begin @(negedge clk); #1; t++; end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  task automatic wait_tx(input string req, input int n);
    int t = 0;
    while (got_data.size() < n && t < 3000) begin @(negedge clk); t++; end
    repeat (6) @(negedge clk);
    chk(req, "beat count", 32'(got_data.size()), 32'(n));
  endtask

  task automatic clear_q();
    got_data.delete();
    got_flag.delete();
  endtask

  initial begin
    logic [31:0] v, hdr;
    logic [31:0] pw[16];
    void'($urandom(32'd20240613));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_STAT, v);
    chk("R1", "status after reset", v, 32'h15);
    chk("R1", "tx_valid after reset", {31'h0, tx_valid}, 32'h0);
    chk("R1", "rx_ready after reset", {31'h0, rx_ready}, 32'h1);

    // R2 payload alone does not start; R3 long packet directed
    sink_en = 1; ready_pct = 100; clear_q();
    wr(A_DATA, 32'h44332211); wr(A_DATA, 32'h88776655); wr(A_DATA, 32'h0000AA99);
    repeat (4) @(negedge clk);
    chk("R2", "beats before header", 32'(got_data.size()), 32'h0);
    rd(A_STAT, v);
    chk("R5", "status with 3 payload words", v, 32'h11);
    wr(A_HDR, 32'h00000A29);
    wait_tx("R3", 4);
    if (got_data.size() == 4) begin
      chk("R3", "long header word", got_data[0], 32'h00000A29);
      chk("R3", "long header flags", 32'(got_flag[0]), 32'h2);
      chk("R3", "payload 0", got_data[1], 32'h44332211);
      chk("R3", "payload 2", got_data[3], 32'h0000AA99);
      chk("R3", "last flag on final word", 32'(got_flag[3]), 32'h1);
    end
    rd(A_STAT, v);
    chk("R10", "status after long packet", v, 32'h15);

    // R3 short packet
    clear_q();
    wr(A_HDR, 32'h00123405);
    wait_tx("R3", 1);
    if (got_data.size() == 1) begin
      chk("R3", "short header", got_data[0], 32'h00123405);
      chk("R3", "short flags", 32'(got_flag[0]), 32'h3);
    end

    // random packets under random back-pressure: R3 R4 R5 R10
    for (int p = 0; p < 40; p++) begin
      logic [15:0] wc;
      logic [5:0] dt;
      logic [1:0] vc;
      int nw;
      bit lng;
      lng = ($urandom_range(0, 1) == 1);
      vc = 2'($urandom_range(0, 3));
      if (lng) begin
        wc = 16'($urandom_range(0, 64));
        dt = {2'($urandom_range(0, 3)), 4'h9};
      end else begin
        wc = 16'($urandom);
        case ($urandom_range(0, 3))
          0: dt = 6'h05;
          1: dt = 6'h15;
          2: dt = 6'h03;
          default: dt = 6'h37;
        endcase
      end
      hdr = {8'h00, wc, vc, dt};
      nw = words_for(hdr);
      ready_pct = int'($urandom_range(20, 100));
      clear_q();
      for (int i = 0; i < nw; i++) begin
        pw[i] = $urandom;
        wr(A_DATA, pw[i]);
      end
      wr(A_HDR, hdr);
      wait_tx("R3", 1 + nw);
      if (got_data.size() == 1 + nw) begin
        chk("R3", "random header", got_data[0], hdr);
        chk("R3", "random header flags", 32'(got_flag[0]), (nw == 0) ? 32'h3 : 32'h2);
        for (int i = 0; i < nw; i++) begin
          chk("R5", "random payload order", got_data[1 + i], pw[i]);
          chk("R3", "random payload flags", 32'(got_flag[1 + i]), (i == nw - 1) ? 32'h1 : 32'h0);
        end
      end
      rd(A_STAT, v);
      chk("R10", "status after random packet", v, 32'h15);
    end

    // R5 R6 payload queue full and overflow
    sink_en = 0; ready_pct = 100; clear_q();
    repeat (2) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      pw[i] = $urandom;
      wr(A_DATA, pw[i]);
    end
    rd(A_STAT, v);
    chk("R5", "payload queue full", v, stat_exp(1, 0, 0, 1, 1, 0, 0, 0));
    wr(A_DATA, 32'hDEADBEEF);
    rd(A_STAT, v);
    chk("R6", "overflow after dropped payload", v, stat_exp(1, 0, 0, 1, 1, 0, 0, 1));
    wr(A_STAT, 32'h0000007F);
    rd(A_STAT, v);
    chk("R6", "overflow kept on write without bit7", v, stat_exp(1, 0, 0, 1, 1, 0, 0, 1));
    wr(A_STAT, 32'h00000080);
    rd(A_STAT, v);
    chk("R6", "overflow cleared", v, stat_exp(1, 0, 0, 1, 1, 0, 0, 0));
    wr(A_HDR, 32'h00004029);
    rd(A_STAT, v);
    chk("R5", "header pending with full payload", v, stat_exp(0, 0, 0, 1, 1, 0, 0, 0));
    sink_en = 1;
    wait_tx("R6", 17);
    if (got_data.size() == 17)
      for (int i = 0; i < 16; i++)
        chk("R6", "kept payload, dropped word absent", got_data[1 + i], pw[i]);
    rd(A_STAT, v);
    chk("R10", "status after full drain", v, 32'h15);

    // R5 R6 command queue full
    sink_en = 0; clear_q();
    repeat (2) @(negedge clk);
    for (int i = 0; i < 4; i++) wr(A_HDR, 32'h00000005 | (32'(i) << 8));
    rd(A_STAT, v);
    chk("R5", "command queue full", v, stat_exp(0, 1, 1, 0, 1, 0, 0, 0));
    wr(A_HDR, 32'h0000FF05);
    rd(A_STAT, v);
    chk("R6", "overflow after dropped header", v, stat_exp(0, 1, 1, 0, 1, 0, 0, 1));
    wr(A_STAT, 32'h00000080);
    sink_en = 1;
    wait_tx("R6", 4);
    if (got_data.size() == 4)
      chk("R6", "last kept header", got_data[3], 32'h00000305);

    // R7 R8 R9 read path
    clear_q();
    wr(A_HDR, 32'h00000114);
    wait_tx("R7", 1);
    rd(A_STAT, v);
    chk("R7", "busy after read request", v, stat_exp(1, 0, 1, 0, 1, 0, 1, 0));
    pw[0] = $urandom; pw[1] = $urandom; pw[2] = $urandom;
    send_rx(pw[0], 0);
    rd(A_STAT, v);
    chk("R7", "busy held before last word", v, stat_exp(1, 0, 1, 0, 0, 0, 1, 0));
    send_rx(pw[1], 0);
    send_rx(pw[2], 1);
    rd(A_STAT, v);
    chk("R7", "busy cleared by last word", v, stat_exp(1, 0, 1, 0, 0, 0, 0, 0));
    for (int i = 0; i < 3; i++) begin
      rd(A_DATA, v);
      chk("R9", "read word order", v, pw[i]);
    end
    rd(A_DATA, v);
    chk("R9", "empty read returns zero", v, 32'h0);
    rd(A_STAT, v);
    chk("R9", "empty read leaves state", v, 32'h15);

    // R8 read queue full
    for (int i = 0; i < 16; i++) begin
      pw[i] = $urandom;
      send_rx(pw[i], 0);
    end
    rd(A_STAT, v);
    chk("R8", "read queue full", v, stat_exp(1, 0, 1, 0, 0, 1, 0, 0));
    chk("R8", "rx_ready low when full", {31'h0, rx_ready}, 32'h0);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 32'hCAFEF00D;
    repeat (3) @(negedge clk);
    rx_valid = 1'b0;
    for (int i = 0; i < 16; i++) begin
      rd(A_DATA, v);
      chk("R8", "read queue content", v, pw[i]);
    end
    rd(A_DATA, v);
    chk("R9", "empty after drain", v, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule